// File: doc/BRIEF.md
# Descriptor-Driven Configuration Item DMA Engine

This block is a bus master that copies firmware configuration items between an item store and system memory. Software places a 16-byte descriptor in memory and writes its address into a 64-bit register. The engine fetches the descriptor one byte at a time. It can optionally select a new item, and then performs one operation against the current item: read it into memory, skip over it, or fill it from memory. It ends by writing a 32-bit status word back over the descriptor's control field.

The current item key and the byte cursor within that item live in one shared cursor. A simple register-side port uses the same cursor: it can select an item and step the cursor by one byte. A DMA run therefore picks up where register-side accesses left off, and the reverse also holds. The item contents sit outside the block behind a combinational lookup keyed by the current key and cursor. Memory is reached through a byte-wide request/acknowledge port. Reading the address register returns slices of a fixed 64-bit signature, so software can detect the engine.

Top module: `cfgdma`

## Requirements
- R1: A register read of `reg_size` bytes at byte offset `reg_addr` returns that slice of the constant 0x51454D5520434647, with offset 0 as the most significant byte, right-aligned in `reg_rdata`. An access that runs past byte 7 reads zero.
- R2: A 4-byte write at offset 0 loads the upper 32 address bits. A 4-byte write at offset 4 loads the lower 32 bits and starts a run. An 8-byte write at offset 0 loads all 64 bits and starts a run. Any other offset or size starts nothing.
- R3: A run first reads 16 descriptor bytes at ascending addresses. They are interpreted big-endian as: control word in bytes 0-3, length in bytes 4-7, target address in bytes 8-15.
- R4: The control bits are: error = bit 0, read = bit 1, skip = bit 2, select = bit 3, write = bit 4. When select is set, control bits 31:16 become the current key, and the cursor is cleared before the operation.
- R5: The operation is chosen with read first, then write, then skip. With none of the three bits set, no data moves and status 0 is written back.
- R6: A read copies item bytes from the cursor position to ascending target addresses. Each byte advances both the cursor and the target address.
- R7: While reading, once the cursor reaches the item end, or when the key names no item, the rest of the length is filled with zero bytes and the cursor stays put.
- R8: A skip advances the cursor by the smaller of the length and the bytes left in the item. When the item is exhausted or absent, it consumes the length without an error.
- R9: A write reads bytes from the target and stores them into the item at the cursor. A write to a read-only item, an absent item or an exhausted item sets the error.
- R10: The status word written big-endian into descriptor bytes 0-3 is 1 on error and 0 otherwise. A failed descriptor fetch writes status 1. A descriptor whose error bit is already set moves no data and gets status 1.
- R11: A memory error on a data beat sets the error and stops the transfer. No later data beats are issued.
- R12: While a run is active, or once it has been started and not yet begun, all register writes are ignored. Each memory beat carries one byte, and a request holds its address until it is acknowledged.
- R13: On the register-side port, a select sets the key and clears the cursor. A step advances the cursor by one, but only while the cursor is inside a present item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| reg_wr | input | 1 | Address register write strobe |
| reg_addr | input | 3 | Byte offset of the register access |
| reg_size | input | 4 | Access size in bytes (1 to 8) |
| reg_wdata | input | 64 | Write data, right-aligned |
| reg_rdata | output | 64 | Signature slice, right-aligned |
| busy | output | 1 | A run is in progress |
| pio_sel | input | 1 | Register-side item select strobe |
| pio_key | input | 16 | Key for the register-side select |
| pio_step | input | 1 | Register-side one-byte cursor advance |
| item_key | output | 16 | Current item key |
| item_offset | output | 32 | Current cursor within the item |
| item_present | input | 1 | The current key names an existing item |
| item_size | input | 32 | Length of the current item in bytes |
| item_writable | input | 1 | The current item accepts writes |
| item_byte | input | 8 | Item byte at the current cursor |
| item_wr | output | 1 | Store `item_wdata` into the item at the cursor |
| item_wdata | output | 8 | Byte to store into the item |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address of the request |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Request failed, valid with `mem_ack` |

## Verification
The assertions take for granted that the memory answers each request with exactly one acknowledge. They also assume the item lookup reflects the key and cursor that the block presents in the same cycle. Finally, they assume the register-side select and step are not used while a run is active. The bench stays within these limits. Its memory model answers in the cycle after a request appears and drops the acknowledge for one cycle before answering again. Its item model is a pure function of key and cursor. It only touches the register-side port after waiting for `busy` to fall.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
  localparam logic [63:0] SIGNATURE = 64'h5145_4d55_2043_4647;

  localparam int ADDR_W     = 64;
  localparam int LEN_W      = 32;
  localparam int KEY_W      = 16;
  localparam int CTRL_W     = 32;
  localparam int DESC_BYTES = 16;
  localparam int STAT_BYTES = 4;
  localparam int DESC_W     = DESC_BYTES * 8;
  localparam int IDX_W      = $clog2(DESC_BYTES);

  // control word bit positions (software visible)
  localparam int CB_ERR  = 0;
  localparam int CB_RD   = 1;
  localparam int CB_SKIP = 2;
  localparam int CB_SEL  = 3;
  localparam int CB_WR   = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SETUP, ST_XFER, ST_STATUS
  } run_state_t;

  typedef enum logic [1:0] {
    OP_NONE, OP_READ, OP_WRITE, OP_SKIP
  } item_op_t;
endpackage

// File: rtl/cfgdma_regs.sv
module cfgdma_regs
  import cfgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [3:0]        reg_size,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic              busy,
  output logic              start,
  output logic [ADDR_W-1:0] desc_addr
);
  logic [63:0] addr_q, addr_d;
  logic        start_q, start_d;
  logic        wr_hi, wr_lo, wr_all, blocked;
  logic [4:0]  span;
  logic [4:0]  rshift;
  logic [63:0] mask;

  assign blocked = busy | start_q;
  assign wr_hi   = reg_wr && reg_size == 4'd4 && reg_addr == 3'd0;
  assign wr_lo   = reg_wr && reg_size == 4'd4 && reg_addr == 3'd4;
  assign wr_all  = reg_wr && reg_size == 4'd8 && reg_addr == 3'd0;

  always_comb begin
    addr_d  = addr_q;
    start_d = 1'b0;
    if (!blocked) begin
      if (wr_hi) begin
        addr_d = {reg_wdata[31:0], addr_q[31:0]};
      end else if (wr_lo) begin
        addr_d  = {addr_q[63:32], reg_wdata[31:0]};
        start_d = 1'b1;
      end else if (wr_all) begin
        addr_d  = reg_wdata;
        start_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      start_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      start_q <= start_d;
    end
  end

  // signature slice: most significant byte sits at offset 0
  assign span   = {2'b00, reg_addr} + {1'b0, reg_size};
  assign rshift = 5'd8 - span;
  assign mask   = ~({64{1'b1}} << {reg_size, 3'b000});

  always_comb begin
    if (span > 5'd8 || reg_size == 4'd0) reg_rdata = '0;
    else reg_rdata = (SIGNATURE >> {rshift, 3'b000}) & mask;
  end

  assign start     = start_q;
  assign desc_addr = addr_q[ADDR_W-1:0];
endmodule

// File: rtl/cfgdma_cursor.sv
module cfgdma_cursor
  import cfgdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pio_sel,
  input  logic [KEY_W-1:0] pio_key,
  input  logic             pio_step,
  input  logic             dma_sel,
  input  logic [KEY_W-1:0] dma_key,
  input  logic             dma_adv,
  input  logic [LEN_W-1:0] dma_adv_n,
  input  logic             item_present,
  input  logic [LEN_W-1:0] item_size,
  output logic [KEY_W-1:0] cur_key,
  output logic [LEN_W-1:0] cur_off
);
  logic [KEY_W-1:0] key_q, key_d;
  logic [LEN_W-1:0] off_q, off_d;

  // engine actions win over the register-side port
  always_comb begin
    key_d = key_q;
    off_d = off_q;
    if (dma_sel) begin
      key_d = dma_key;
      off_d = '0;
    end else if (dma_adv) begin
      off_d = off_q + dma_adv_n;
    end else if (pio_sel) begin
      key_d = pio_key;
      off_d = '0;
    end else if (pio_step && item_present && off_q < item_size) begin
      off_d = off_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      off_q <= '0;
    end else begin
      key_q <= key_d;
      off_q <= off_d;
    end
  end

  assign cur_key = key_q;
  assign cur_off = off_q;
endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
  import cfgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic              dma_sel,
  output logic [KEY_W-1:0]  dma_key,
  output logic              dma_adv,
  output logic [LEN_W-1:0]  dma_adv_n,
  input  logic [LEN_W-1:0]  cur_off,
  input  logic              item_present,
  input  logic [LEN_W-1:0]  item_size,
  input  logic              item_writable,
  input  logic [7:0]        item_byte,
  output logic              item_wr,
  output logic [7:0]        item_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err
);
  run_state_t        st_q, st_d;
  item_op_t          op_q, op_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] base_q, base_d, tgt_q, tgt_d;
  logic [DESC_W-1:0] sr_q, sr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              err_q, err_d;

  logic [CTRL_W-1:0] ctrl;
  logic              exhausted, loop_done;
  logic [LEN_W-1:0]  left, chunk;

  assign ctrl      = sr_q[DESC_W-1 -: CTRL_W];
  assign exhausted = !item_present || cur_off >= item_size;
  assign left      = item_size - cur_off;
  assign chunk     = (rem_q < left) ? rem_q : left;
  assign loop_done = rem_q == '0 || err_q;

  always_comb begin
    st_d = st_q;  op_d = op_q;  idx_d = idx_q;  base_d = base_q;
    tgt_d = tgt_q;  sr_d = sr_q;  rem_d = rem_q;  err_d = err_q;
    mem_req = 1'b0;  mem_we = 1'b0;  mem_addr = tgt_q;  mem_wdata = '0;
    dma_sel = 1'b0;  dma_key = ctrl[31:16];
    dma_adv = 1'b0;  dma_adv_n = LEN_W'(1);
    item_wr = 1'b0;  item_wdata = mem_rdata;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          base_d = start_addr;
          idx_d  = '0;
          err_d  = 1'b0;
          st_d   = ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = base_q + ADDR_W'(idx_q);
        if (mem_ack) begin
          if (mem_err) begin
            err_d = 1'b1;
            idx_d = '0;
            st_d  = ST_STATUS;
          end else begin
            sr_d  = {sr_q[DESC_W-9:0], mem_rdata};
            idx_d = idx_q + IDX_W'(1);
            if (idx_q == IDX_W'(DESC_BYTES - 1)) st_d = ST_SETUP;
          end
        end
      end
      ST_SETUP: begin
        rem_d   = sr_q[ADDR_W +: LEN_W];
        tgt_d   = sr_q[ADDR_W-1:0];
        err_d   = ctrl[CB_ERR];
        dma_sel = ctrl[CB_SEL];
        idx_d   = '0;
        if (ctrl[CB_RD])        op_d = OP_READ;
        else if (ctrl[CB_WR])   op_d = OP_WRITE;
        else if (ctrl[CB_SKIP]) op_d = OP_SKIP;
        else                    op_d = OP_NONE;
        st_d = (op_d == OP_NONE) ? ST_STATUS : ST_XFER;
      end
      ST_XFER: begin
        if (loop_done) begin
          st_d = ST_STATUS;
        end else begin
          unique case (op_q)
            OP_READ: begin
              mem_req   = 1'b1;
              mem_we    = 1'b1;
              mem_wdata = exhausted ? 8'h00 : item_byte;
              if (mem_ack) begin
                if (mem_err) begin
                  err_d = 1'b1;
                end else begin
                  rem_d   = rem_q - LEN_W'(1);
                  tgt_d   = tgt_q + ADDR_W'(1);
                  dma_adv = !exhausted;
                end
              end
            end
            OP_SKIP: begin
              if (exhausted) begin
                rem_d = '0;
              end else begin
                rem_d     = rem_q - chunk;
                tgt_d     = tgt_q + ADDR_W'(chunk);
                dma_adv   = 1'b1;
                dma_adv_n = chunk;
              end
            end
            OP_WRITE: begin
              if (exhausted || !item_writable) begin
                err_d = 1'b1;
              end else begin
                mem_req = 1'b1;
                if (mem_ack) begin
                  if (mem_err) begin
                    err_d = 1'b1;
                  end else begin
                    item_wr = 1'b1;
                    dma_adv = 1'b1;
                    rem_d   = rem_q - LEN_W'(1);
                    tgt_d   = tgt_q + ADDR_W'(1);
                  end
                end
              end
            end
            default: st_d = ST_STATUS;
          endcase
        end
      end
      ST_STATUS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = base_q + ADDR_W'(idx_q);
        mem_wdata = (idx_q == IDX_W'(STAT_BYTES - 1)) ? {7'b0, err_q} : 8'h00;
        if (mem_ack) begin
          idx_d = idx_q + IDX_W'(1);
          if (mem_err || idx_q == IDX_W'(STAT_BYTES - 1)) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  op_q <= OP_NONE;  idx_q <= '0;  base_q <= '0;
      tgt_q <= '0;  sr_q <= '0;  rem_q <= '0;  err_q <= 1'b0;
    end else begin
      st_q <= st_d;  op_q <= op_d;  idx_q <= idx_d;  base_q <= base_d;
      tgt_q <= tgt_d;  sr_q <= sr_d;  rem_q <= rem_d;  err_q <= err_d;
    end
  end

  assign busy = st_q != ST_IDLE;
endmodule

// File: rtl/cfgdma.sv
module cfgdma
  import cfgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [3:0]        reg_size,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              busy,
  input  logic              pio_sel,
  input  logic [KEY_W-1:0]  pio_key,
  input  logic              pio_step,
  output logic [KEY_W-1:0]  item_key,
  output logic [LEN_W-1:0]  item_offset,
  input  logic              item_present,
  input  logic [LEN_W-1:0]  item_size,
  input  logic              item_writable,
  input  logic [7:0]        item_byte,
  output logic              item_wr,
  output logic [7:0]        item_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err
);
  logic              start;
  logic [ADDR_W-1:0] desc_addr;
  logic              dma_sel, dma_adv;
  logic [KEY_W-1:0]  dma_key;
  logic [LEN_W-1:0]  dma_adv_n;

  cfgdma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .start(start), .desc_addr(desc_addr)
  );

  cfgdma_cursor u_cursor (
    .clk(clk), .rst_n(rst_n), .pio_sel(pio_sel), .pio_key(pio_key),
    .pio_step(pio_step), .dma_sel(dma_sel), .dma_key(dma_key),
    .dma_adv(dma_adv), .dma_adv_n(dma_adv_n), .item_present(item_present),
    .item_size(item_size), .cur_key(item_key), .cur_off(item_offset)
  );

  cfgdma_engine u_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(desc_addr),
    .busy(busy), .dma_sel(dma_sel), .dma_key(dma_key), .dma_adv(dma_adv),
    .dma_adv_n(dma_adv_n), .cur_off(item_offset), .item_present(item_present),
    .item_size(item_size), .item_writable(item_writable),
    .item_byte(item_byte), .item_wr(item_wr), .item_wdata(item_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err)
  );
endmodule

// File: rtl/cfgdma_checker.sv
module cfgdma_checker
  import cfgdma_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              mem_err,
  input logic              item_wr,
  input logic              item_writable
);
  // R12: a pending request keeps its address and direction
  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R12: nothing is driven towards memory or the item while idle
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !item_wr);

  // R9: an item store only follows a good read beat on a writable item
  a_r9_store_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    item_wr |-> item_writable && mem_ack && !mem_err && !mem_we);

  // R3: a run opens with a descriptor read
  a_r3_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_req && !mem_we);
endmodule

bind cfgdma cfgdma_checker u_chk (.*);

// File: tb/cfgdma_test.sv
`timescale 1ns/1ps
module cfgdma_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [3:0]  reg_size;
  logic [63:0] reg_wdata, reg_rdata;
  logic        busy;
  logic        pio_sel, pio_step;
  logic [15:0] pio_key, item_key;
  logic [31:0] item_offset, item_size;
  logic        item_present, item_writable, item_wr;
  logic [7:0]  item_byte, item_wdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0]  mem [256];
  logic [7:0]  it5 [6];
  logic        h_en;
  logic [7:0]  h_addr, h_data;
  logic        err_on;
  logic [7:0]  err_addr;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  cfgdma uut (.*);

  // item model: key 0 read-only A1 B2 C3 D4, key 5 writable 6 bytes
  always_comb begin
    item_present = 1'b0; item_size = 0; item_writable = 1'b0; item_byte = 8'h00;
    if (item_key == 16'd0) begin
      item_present = 1'b1; item_size = 4;
      if (item_offset < 4) item_byte = 8'hA1 + 8'(item_offset) * 8'h11;
    end else if (item_key == 16'd5) begin
      item_present = 1'b1; item_size = 6; item_writable = 1'b1;
      if (item_offset < 6) item_byte = it5[item_offset[2:0]];
    end
  end

  // memory and item storage, single writer
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= 8'h00;
      for (int i = 0; i < 6; i++) it5[i] <= 8'h50 + 8'(i);
    end else begin
      if (h_en) mem[h_addr] <= h_data;
      if (mem_req && !mem_ack) begin
        mem_ack   <= 1'b1;
        mem_err   <= err_on && mem_addr[7:0] == err_addr;
        mem_rdata <= mem[mem_addr[7:0]];
        if (mem_we && !(err_on && mem_addr[7:0] == err_addr))
          mem[mem_addr[7:0]] <= mem_wdata;
      end else begin
        mem_ack <= 1'b0; mem_err <= 1'b0;
      end
      if (item_wr && item_key == 16'd5 && item_offset < 6)
        it5[item_offset[2:0]] <= item_wdata;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); h_en = 1'b1; h_addr = a; h_data = d;
    @(negedge clk); h_en = 1'b0;
  endtask

  function automatic logic [31:0] word_at(input logic [7:0] a);
    return {mem[a], mem[8'(a + 1)], mem[8'(a + 2)], mem[8'(a + 3)]};
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [3:0] s, input logic [63:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_size = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, input logic [3:0] s, output logic [63:0] d);
    @(negedge clk); reg_addr = a; reg_size = s; #1 d = reg_rdata;
  endtask

  task automatic wait_done();
    int n = 0;
    repeat (3) @(negedge clk);
    while (busy && n < 5000) begin @(negedge clk); n++; end
    if (busy) begin errors++; $display("FAIL R12: run never ended"); end
  endtask

  task automatic put_desc(input logic [7:0] b, input logic [31:0] ctl,
                          input logic [31:0] len, input logic [7:0] tgt);
    logic [127:0] d = {ctl, len, 56'h0, tgt};
    for (int i = 0; i < 16; i++) poke(8'(b + 8'(i)), d[127 - 8*i -: 8]);
  endtask

  task automatic run(input logic [7:0] b, input logic [31:0] ctl,
                     input logic [31:0] len, input logic [7:0] tgt);
    put_desc(b, ctl, len, tgt);
    reg_write(3'd0, 4'd4, 64'h0);
    reg_write(3'd4, 4'd4, {56'h0, b});
    wait_done();
  endtask

  task automatic t_reset();
    logic [63:0] r;
    check("R12 reset busy", busy, 0);
    check("R13 reset key", item_key, 0);
    check("R13 reset offset", item_offset, 0);
    reg_read(3'd0, 4'd8, r); check("R1 full signature", r, 64'h5145_4d55_2043_4647);
  endtask

  task automatic t_signature();
    logic [63:0] r;
    reg_read(3'd0, 4'd4, r); check("R1 upper word", r, 64'h5145_4d55);
    reg_read(3'd4, 4'd4, r); check("R1 lower word", r, 64'h2043_4647);
    reg_read(3'd2, 4'd2, r); check("R1 mid half", r, 64'h4d55);
    reg_read(3'd7, 4'd1, r); check("R1 last byte", r, 64'h47);
    reg_read(3'd6, 4'd4, r); check("R1 overrun", r, 64'h0);
  endtask

  task automatic t_busy_block();
    put_desc(8'h20, 32'h0000_000A, 32'd4, 8'h60);
    for (int i = 0; i < 4; i++) poke(8'h30 + 8'(i), 8'hFF);
    reg_write(3'd0, 4'd4, 64'h0);
    reg_write(3'd4, 4'd4, 64'h20);
    reg_write(3'd4, 4'd4, 64'h30);   // arrives while run is starting
    wait_done();
    check("R12 first status", word_at(8'h20), 0);
    check("R12 blocked start left status", word_at(8'h30), 32'hFFFF_FFFF);
    check("R6 read data", word_at(8'h60), 32'hA1B2_C3D4);
    reg_write(3'd2, 4'd4, 64'h20);
    @(negedge clk);
    check("R2 bad offset starts nothing", busy, 0);
    put_desc(8'h30, 32'h0000_0008, 32'd0, 8'h00);
    reg_write(3'd0, 4'd8, 64'h30);
    wait_done();
    check("R2 wide write starts", word_at(8'h30), 0);
  endtask

  task automatic t_read_fill();
    poke(8'h84, 8'hEE); poke(8'h85, 8'hEE);
    run(8'h40, 32'h0000_000A, 32'd6, 8'h80);
    check("R6 item bytes", word_at(8'h80), 32'hA1B2_C3D4);
    check("R7 zero fill", {mem[8'h84], mem[8'h85]}, 16'h0000);
    check("R7 offset stops at end", item_offset, 4);
    check("R10 good status", word_at(8'h40), 0);
  endtask

  task automatic t_shared_cursor();
    @(negedge clk); pio_sel = 1'b1; pio_key = 16'd0;
    @(negedge clk); pio_sel = 1'b0; pio_step = 1'b1;
    repeat (2) @(negedge clk);
    pio_step = 1'b0;
    check("R13 two steps", item_offset, 2);
    pio_step = 1'b1; repeat (4) @(negedge clk); pio_step = 1'b0;
    check("R13 step capped", item_offset, 4);
    @(negedge clk); pio_sel = 1'b1; @(negedge clk); pio_sel = 1'b0;
    check("R13 select clears", item_offset, 0);
    pio_step = 1'b1; repeat (2) @(negedge clk); pio_step = 1'b0;
    run(8'h40, 32'h0000_0002, 32'd1, 8'h88);
    check("R6 continues from shared cursor", mem[8'h88], 8'hC3);
    check("R6 cursor advanced", item_offset, 3);
  endtask

  task automatic t_skip();
    run(8'h40, 32'h0005_000C, 32'd3, 8'h90);
    check("R4 select key", item_key, 5);
    check("R8 skip advance", item_offset, 3);
    run(8'h40, 32'h0000_0002, 32'd2, 8'h98);
    check("R8 read after skip", {mem[8'h98], mem[8'h99]}, 16'h5354);
    run(8'h40, 32'h0000_0004, 32'd10, 8'h90);
    check("R8 skip past end", item_offset, 6);
    check("R8 skip past end status", word_at(8'h40), 0);
  endtask

  task automatic t_write();
    poke(8'hA0, 8'h11); poke(8'hA1, 8'h22);
    run(8'h40, 32'h0005_0018, 32'd2, 8'hA0);
    check("R9 write status", word_at(8'h40), 0);
    check("R9 write cursor", item_offset, 2);
    run(8'h40, 32'h0005_000A, 32'd2, 8'hB0);
    check("R9 stored bytes", {mem[8'hB0], mem[8'hB1]}, 16'h1122);
    run(8'h40, 32'h0000_0018, 32'd1, 8'hA0);
    check("R9 read-only error", word_at(8'h40), 1);
    run(8'h40, 32'h0000_000A, 32'd1, 8'hB4);
    check("R9 read-only unchanged", mem[8'hB4], 8'hA1);
  endtask

  task automatic t_priority();
    poke(8'hC8, 8'hEE);
    run(8'h40, 32'h0005_001E, 32'd1, 8'hC0);
    check("R5 read wins", mem[8'hC0], 8'h11);
    check("R5 read wins status", word_at(8'h40), 0);
    run(8'h40, 32'h0005_0008, 32'd4, 8'hC8);
    check("R5 no op moves nothing", mem[8'hC8], 8'hEE);
    check("R5 no op status", word_at(8'h40), 0);
    check("R4 select clears cursor", item_offset, 0);
  endtask

  task automatic t_errors();
    poke(8'hD0, 8'hEE);
    run(8'h40, 32'h0000_000B, 32'd2, 8'hD0);
    check("R10 preset error no data", mem[8'hD0], 8'hEE);
    check("R10 preset error status", word_at(8'h40), 1);
    put_desc(8'h40, 32'h0000_000A, 32'd2, 8'hD0);
    for (int i = 0; i < 4; i++) poke(8'h40 + 8'(i), 8'hFF);
    err_on = 1'b1; err_addr = 8'h45;
    reg_write(3'd0, 4'd4, 64'h0); reg_write(3'd4, 4'd4, 64'h40); wait_done();
    err_on = 1'b0;
    check("R10 fetch failure status", word_at(8'h40), 1);
    check("R10 fetch failure no data", mem[8'hD0], 8'hEE);
    poke(8'hE2, 8'hEE);
    err_on = 1'b1; err_addr = 8'hE1;
    run(8'h40, 32'h0000_000A, 32'd4, 8'hE0);
    err_on = 1'b0;
    check("R11 first byte kept", mem[8'hE0], 8'hA1);
    check("R11 loop stopped", mem[8'hE2], 8'hEE);
    check("R11 status", word_at(8'h40), 1);
    check("R11 cursor", item_offset, 1);
  endtask

  task automatic t_absent();
    poke(8'hF0, 8'hEE); poke(8'hF1, 8'hEE);
    run(8'h40, 32'h0009_000A, 32'd2, 8'hF0);
    check("R7 absent item zeros", {mem[8'hF0], mem[8'hF1]}, 16'h0000);
    check("R7 absent status", word_at(8'h40), 0);
  endtask

  initial begin
    #(20.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_size = 4'd8; reg_wdata = '0;
    pio_sel = 1'b0; pio_step = 1'b0; pio_key = '0;
    h_en = 1'b0; h_addr = '0; h_data = '0; err_on = 1'b0; err_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_signature();
    t_busy_block();
    t_read_fill();
    t_shared_cursor();
    t_skip();
    t_write();
    t_priority();
    t_errors();
    t_absent();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule